// File: doc/BRIEF.md
# Bit-Addressable Data Memory

This block is the byte-wide data store of a small 8-bit controller core. It holds 128 bytes in two ranges. The low range is 112 bytes of general RAM at addresses 0x00 to 0x6F. The high range is a 16-byte register window at 0xF0 to 0xFF. The addresses in between are an unimplemented gap. Three bytes of the window act as address pointers: X at 0xFC, B at 0xFD and SP at 0xFE. The other window bytes are general purpose.

The core issues one command per clock on `op_i`, together with an address mode, an address, a bit index and a data byte. Commands can:
- read or write a whole byte;
- set, clear or test a single bit at any address;
- load an immediate value into a window byte;
- decrement a window byte and flag when it reaches zero.

The address comes either directly from `addr_i` or from one of the three pointer bytes. Read data, tested bits and the zero flag appear on registered outputs one cycle after the command.

Top module: `dm_bitmem`

## Requirements
- R1: A write (op 2) to any implemented address stores `wdata_i`, and a later read (op 1) of that address shows the byte on `rdata_o` in the cycle after the read command. Implemented addresses are 0x00..0x6F and 0xF0..0xFF. `rdata_o` holds its value during all other commands.
- R2: Addresses 0x70..0xEF read as 0x00. Write, set, clear, load and decrement commands at these addresses change nothing.
- R3: Reset drives `rdata_o`, `bit_o` and `skip_o` to 0 and sets SP (0xFE) to 0x6F. All other bytes are undefined after reset.
- R4: Set-bit (op 3) forces bit `bit_i` of the addressed byte to 1 in one cycle and leaves the other seven bits unchanged.
- R5: Clear-bit (op 4) forces bit `bit_i` of the addressed byte to 0 in one cycle and leaves the other seven bits unchanged.
- R6: Test-bit (op 5) places bit `bit_i` of the addressed byte on `bit_o` one cycle later. Unimplemented addresses test as 0. `bit_o` holds its value during other commands.
- R7: Load-immediate (op 6) writes `wdata_i` to a window address (0xF0..0xFF). At any other address it is ignored.
- R8: Decrement-and-skip (op 7) on a window address stores the byte minus one, wrapping 0x00 to 0xFF. `skip_o` is high in the following cycle only if the stored result is zero. At any other address the command is ignored and `skip_o` stays low.
- R9: Address mode 0 uses `addr_i` as the address. Modes 1, 2 and 3 use the current byte at 0xFC, 0xFD or 0xFE respectively.
- R10: Commands issued on consecutive cycles each see the result of the command before, including a read-modify-write followed at once by a read of the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command: 0 idle, 1 read, 2 write, 3 set bit, 4 clear bit, 5 test bit, 6 load immediate, 7 decrement-and-skip |
| amode_i | input | 2 | Address mode: 0 direct, 1 via X, 2 via B, 3 via SP |
| addr_i | input | 8 | Direct address |
| bit_i | input | 3 | Bit index for set, clear and test |
| wdata_i | input | 8 | Write or immediate data |
| rdata_o | output | 8 | Read result, registered |
| bit_o | output | 1 | Test-bit result, registered |
| skip_o | output | 1 | Zero flag from decrement-and-skip, one-cycle pulse |

## Verification
The hardest situations to reach are the pointer-indirect accesses that land in the unimplemented gap, and back-to-back decrements that hit zero in successive cycles. Each of these needs the window to be primed first with load-immediate commands. For the gap case, the stimulus loads X with 0x80, writes through X, and reads back through X, expecting zero. For the zero case, it loads two window bytes with 0x01 and decrements them on adjacent cycles, which must give two consecutive skip pulses. A wrap from 0x00 to 0xFF is also driven, and it must not flag.

// File: rtl/dm_pkg.sv
package dm_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_RD   = 3'd1,
      OP_WR   = 3'd2,
      OP_SETB = 3'd3,
      OP_CLRB = 3'd4,
      OP_TSTB = 3'd5,
      OP_LDI  = 3'd6,
      OP_DRSZ = 3'd7
   } dm_op_e;

   typedef enum logic [1:0] {
      AM_DIR = 2'd0,
      AM_X   = 2'd1,
      AM_B   = 2'd2,
      AM_SP  = 2'd3
   } dm_amode_e;
endpackage

// File: rtl/dm_addr_gen.sv
module dm_addr_gen
   import dm_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int LOW_DEPTH = 112,
   parameter int WIN_BASE  = 240,
   parameter int WIN_DEPTH = 16
) (
   input  logic [1:0]        amode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] ptr_x_i,
   input  logic [ADDR_W-1:0] ptr_b_i,
   input  logic [ADDR_W-1:0] ptr_sp_i,
   output logic [ADDR_W-1:0] eff_o,
   output logic              low_hit_o,
   output logic              win_hit_o
);
   localparam logic [ADDR_W:0] LOW_END = (ADDR_W+1)'(LOW_DEPTH);
   localparam logic [ADDR_W:0] WIN_LO  = (ADDR_W+1)'(WIN_BASE);
   localparam logic [ADDR_W:0] WIN_HI  = (ADDR_W+1)'(WIN_BASE + WIN_DEPTH);

   logic [ADDR_W:0] eff_ext;

   always_comb begin
      unique case (dm_amode_e'(amode_i))
         AM_X:    eff_o = ptr_x_i;
         AM_B:    eff_o = ptr_b_i;
         AM_SP:   eff_o = ptr_sp_i;
         default: eff_o = addr_i;
      endcase
   end

   assign eff_ext   = {1'b0, eff_o};
   assign low_hit_o = eff_ext < LOW_END;
   assign win_hit_o = (eff_ext >= WIN_LO) && (eff_ext < WIN_HI);
endmodule

// File: rtl/dm_regwin.sv
module dm_regwin #(
   parameter int          DATA_W    = 8,
   parameter int          WIN_DEPTH = 16,
   parameter int          X_OFS     = 12,
   parameter int          B_OFS     = 13,
   parameter int          SP_OFS    = 14,
   parameter logic [7:0]  SP_INIT   = 8'h6F,
   localparam int         WIN_AW    = $clog2(WIN_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [WIN_AW-1:0] idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] ptr_x_o,
   output logic [DATA_W-1:0] ptr_b_o,
   output logic [DATA_W-1:0] ptr_sp_o
);
   logic [DATA_W-1:0] regs [WIN_DEPTH];

   for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_byte
      logic [DATA_W-1:0] q;
      logic              sel;
      assign sel = we_i && (idx_i == WIN_AW'(g));
      if (g == SP_OFS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= DATA_W'(SP_INIT);
            else if (sel) q <= wdata_i;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (sel) q <= wdata_i;
         end
      end
      assign regs[g] = q;
   end

   assign rdata_o  = regs[idx_i];
   assign ptr_x_o  = regs[X_OFS];
   assign ptr_b_o  = regs[B_OFS];
   assign ptr_sp_o = regs[SP_OFS];
endmodule

// File: rtl/dm_lowram.sv
module dm_lowram #(
   parameter int  DATA_W = 8,
   parameter int  DEPTH  = 112,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [AW-1:0]     idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[idx_i] <= wdata_i;
   end

   assign rdata_o = mem[idx_i];
endmodule

// File: rtl/dm_bitmem.sv
module dm_bitmem
   import dm_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          ADDR_W    = 8,
   parameter int          LOW_DEPTH = 112,
   parameter int          WIN_BASE  = 240,
   parameter int          WIN_DEPTH = 16,
   parameter int          X_OFS     = 12,
   parameter int          B_OFS     = 13,
   parameter int          SP_OFS    = 14,
   parameter logic [7:0]  SP_INIT   = 8'h6F,
   localparam int         BIT_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic [1:0]        amode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BIT_W-1:0]  bit_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              bit_o,
   output logic              skip_o
);
   localparam int LOW_AW = $clog2(LOW_DEPTH);
   localparam int WIN_AW = $clog2(WIN_DEPTH);

   if (DATA_W != ADDR_W) begin : g_bad_width
      $error("pointer bytes must be as wide as the address");
   end
   if (LOW_DEPTH > WIN_BASE) begin : g_bad_overlap
      $error("low RAM overlaps the register window");
   end
   if ((WIN_BASE % WIN_DEPTH) != 0 || (1 << WIN_AW) != WIN_DEPTH) begin : g_bad_align
      $error("window must be a power of two and aligned to its size");
   end
   if (WIN_BASE + WIN_DEPTH > (1 << ADDR_W)) begin : g_bad_top
      $error("window exceeds the address space");
   end
   if (X_OFS >= WIN_DEPTH || B_OFS >= WIN_DEPTH || SP_OFS >= WIN_DEPTH) begin : g_bad_ptr
      $error("pointer offsets must lie inside the window");
   end

   dm_op_e            op;
   logic [ADDR_W-1:0] eff;
   logic              low_hit, win_hit, eff_hit;
   logic [DATA_W-1:0] ptr_x, ptr_b, ptr_sp;
   logic [DATA_W-1:0] low_rd, win_rd, cur_byte, new_byte, mask;
   logic              wr_en;
   logic [DATA_W-1:0] rdata_q;
   logic              bit_q, skip_q;

   assign op = dm_op_e'(op_i);

   dm_addr_gen #(
      .ADDR_W(ADDR_W), .LOW_DEPTH(LOW_DEPTH),
      .WIN_BASE(WIN_BASE), .WIN_DEPTH(WIN_DEPTH)
   ) agen_i (
      .amode_i(amode_i), .addr_i(addr_i),
      .ptr_x_i(ptr_x), .ptr_b_i(ptr_b), .ptr_sp_i(ptr_sp),
      .eff_o(eff), .low_hit_o(low_hit), .win_hit_o(win_hit)
   );

   dm_lowram #(.DATA_W(DATA_W), .DEPTH(LOW_DEPTH)) lram_i (
      .clk(clk), .we_i(wr_en && low_hit), .idx_i(LOW_AW'(eff)),
      .wdata_i(new_byte), .rdata_o(low_rd)
   );

   dm_regwin #(
      .DATA_W(DATA_W), .WIN_DEPTH(WIN_DEPTH),
      .X_OFS(X_OFS), .B_OFS(B_OFS), .SP_OFS(SP_OFS), .SP_INIT(SP_INIT)
   ) rwin_i (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en && win_hit), .idx_i(WIN_AW'(eff)),
      .wdata_i(new_byte), .rdata_o(win_rd),
      .ptr_x_o(ptr_x), .ptr_b_o(ptr_b), .ptr_sp_o(ptr_sp)
   );

   assign eff_hit  = low_hit || win_hit;
   assign cur_byte = low_hit ? low_rd : (win_hit ? win_rd : '0);
   assign mask     = DATA_W'(1) << bit_i;

   always_comb begin
      new_byte = cur_byte;
      wr_en    = 1'b0;
      unique case (op)
         OP_WR:   begin new_byte = wdata_i;            wr_en = 1'b1;    end
         OP_SETB: begin new_byte = cur_byte | mask;    wr_en = 1'b1;    end
         OP_CLRB: begin new_byte = cur_byte & ~mask;   wr_en = 1'b1;    end
         OP_LDI:  begin new_byte = wdata_i;            wr_en = win_hit; end
         OP_DRSZ: begin new_byte = cur_byte - 1'b1;    wr_en = win_hit; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         bit_q   <= 1'b0;
         skip_q  <= 1'b0;
      end else begin
         if (op == OP_RD)   rdata_q <= cur_byte;
         if (op == OP_TSTB) bit_q   <= cur_byte[bit_i];
         skip_q <= (op == OP_DRSZ) && win_hit && (cur_byte == DATA_W'(1));
      end
   end

   assign rdata_o = rdata_q;
   assign bit_o   = bit_q;
   assign skip_o  = skip_q;
endmodule

// File: rtl/dm_bitmem_chk.sv
module dm_bitmem_chk
   import dm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op_i,
   input logic              eff_hit,
   input logic              win_hit,
   input logic [DATA_W-1:0] rdata_o,
   input logic              bit_o,
   input logic              skip_o
);
   p_skip_after_drsz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> ($past(op_i) == OP_DRSZ) && $past(win_hit));

   p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_o) |-> ($past(op_i) == OP_RD));

   p_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bit_o) |-> ($past(op_i) == OP_TSTB));

   p_gap_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_RD && !eff_hit) |=> (rdata_o == '0));

   p_gap_tests_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_TSTB && !eff_hit) |=> !bit_o);
endmodule

bind dm_bitmem dm_bitmem_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .eff_hit(eff_hit), .win_hit(win_hit),
   .rdata_o(rdata_o), .bit_o(bit_o), .skip_o(skip_o)
);

// File: tb/dm_bitmem_tb_top.sv
module dm_bitmem_tb_top;
   import dm_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] op_i;
   logic [1:0] amode_i;
   logic [7:0] addr_i;
   logic [2:0] bit_i;
   logic [7:0] wdata_i;
   logic [7:0] rdata_o;
   logic       bit_o;
   logic       skip_o;

   always #2 clk = ~clk;

   dm_bitmem dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .amode_i(amode_i), .addr_i(addr_i),
      .bit_i(bit_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .bit_o(bit_o), .skip_o(skip_o)
   );

   typedef struct {
      logic [7:0] rd;
      logic       bt;
      logic       sk;
      string      tag;
   } item_t;

   item_t      sb_q[$];
   item_t      mon_it;
   logic [7:0] model [256];
   logic [7:0] exp_rd;
   logic       exp_bt;
   int         errors = 0;
   int         checks = 0;
   bit         done   = 1'b0;

   function automatic bit in_low(logic [7:0] a);
      return a < 8'h70;
   endfunction
   function automatic bit in_win(logic [7:0] a);
      return a >= 8'hF0;
   endfunction
   function automatic logic [7:0] eff_of(dm_amode_e am, logic [7:0] a);
      case (am)
         AM_X:    return model[8'hFC];
         AM_B:    return model[8'hFD];
         AM_SP:   return model[8'hFE];
         default: return a;
      endcase
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic issue(dm_op_e op, dm_amode_e am, logic [7:0] a, logic [2:0] b,
                        logic [7:0] d, string tag);
      logic [7:0] e, cur;
      item_t      it;
      @(negedge clk);
      op_i = op; amode_i = am; addr_i = a; bit_i = b; wdata_i = d;
      e   = eff_of(am, a);
      cur = (in_low(e) || in_win(e)) ? model[e] : 8'h00;
      it.sk = 1'b0;
      case (op)
         OP_RD:   exp_rd = cur;
         OP_WR:   if (in_low(e) || in_win(e)) model[e] = d;
         OP_SETB: if (in_low(e) || in_win(e)) model[e] = cur | (8'h01 << b);
         OP_CLRB: if (in_low(e) || in_win(e)) model[e] = cur & ~(8'h01 << b);
         OP_TSTB: exp_bt = cur[b];
         OP_LDI:  if (in_win(e)) model[e] = d;
         OP_DRSZ: if (in_win(e)) begin
                     model[e] = cur - 8'h01;
                     it.sk = (cur == 8'h01);
                  end
         default: ;
      endcase
      it.rd = exp_rd; it.bt = exp_bt; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: each command's results are due just after the next rising edge.
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         mon_it = sb_q.pop_front();
         check(mon_it.tag, "rdata_o", rdata_o, mon_it.rd);
         check(mon_it.tag, "bit_o", {7'd0, bit_o}, {7'd0, mon_it.bt});
         check(mon_it.tag, "skip_o", {7'd0, skip_o}, {7'd0, mon_it.sk});
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; op_i = OP_NOP; amode_i = AM_DIR; addr_i = '0; bit_i = '0; wdata_i = '0;
      foreach (model[i]) model[i] = 8'h00;
      model[8'hFE] = 8'h6F;
      exp_rd = 8'h00; exp_bt = 1'b0;
      repeat (3) @(negedge clk);
      check("R3", "rdata_o at reset", rdata_o, 8'h00);
      check("R3", "bit_o at reset", {7'd0, bit_o}, 8'h00);
      check("R3", "skip_o at reset", {7'd0, skip_o}, 8'h00);
      rst_n = 1'b1;

      issue(OP_RD, AM_DIR, 8'hFE, 0, 0, "R3");

      // R1: fill every implemented byte, then read boundaries
      for (int a = 0; a < 256; a++) begin
         if (in_low(8'(a)) || in_win(8'(a)))
            issue(OP_WR, AM_DIR, 8'(a), 0, 8'(a) ^ 8'hA5, "R1");
      end
      issue(OP_RD, AM_DIR, 8'h00, 0, 0, "R1");
      issue(OP_RD, AM_DIR, 8'h6F, 0, 0, "R1");
      issue(OP_RD, AM_DIR, 8'hF0, 0, 0, "R1");
      issue(OP_RD, AM_DIR, 8'hFF, 0, 0, "R1");
      issue(OP_RD, AM_DIR, 8'h35, 0, 0, "R1");

      // R2: gap addresses
      issue(OP_WR, AM_DIR, 8'h70, 0, 8'hAA, "R2");
      issue(OP_RD, AM_DIR, 8'h70, 0, 0, "R2");
      issue(OP_SETB, AM_DIR, 8'hEF, 5, 0, "R2");
      issue(OP_RD, AM_DIR, 8'hEF, 0, 0, "R2");
      issue(OP_RD, AM_DIR, 8'h6F, 0, 0, "R2");
      issue(OP_RD, AM_DIR, 8'hF0, 0, 0, "R2");

      // R4 / R5: set and clear in low RAM and window
      issue(OP_SETB, AM_DIR, 8'h40, 1, 0, "R4");
      issue(OP_RD, AM_DIR, 8'h40, 0, 0, "R4");
      issue(OP_SETB, AM_DIR, 8'hF1, 6, 0, "R4");
      issue(OP_RD, AM_DIR, 8'hF1, 0, 0, "R4");
      issue(OP_CLRB, AM_DIR, 8'h40, 7, 0, "R5");
      issue(OP_RD, AM_DIR, 8'h40, 0, 0, "R5");
      issue(OP_CLRB, AM_DIR, 8'hF1, 4, 0, "R5");
      issue(OP_RD, AM_DIR, 8'hF1, 0, 0, "R5");

      // R10: back-to-back read-modify-write chains
      issue(OP_SETB, AM_DIR, 8'h41, 3, 0, "R10");
      issue(OP_CLRB, AM_DIR, 8'h41, 0, 0, "R10");
      issue(OP_SETB, AM_DIR, 8'h41, 4, 0, "R10");
      issue(OP_RD, AM_DIR, 8'h41, 0, 0, "R10");
      issue(OP_WR, AM_DIR, 8'h42, 0, 8'h3C, "R10");
      issue(OP_RD, AM_DIR, 8'h42, 0, 0, "R10");

      // R6: test every bit of one byte, and a gap address
      for (int b = 0; b < 8; b++) issue(OP_TSTB, AM_DIR, 8'h40, 3'(b), 0, "R6");
      issue(OP_TSTB, AM_DIR, 8'hF1, 6, 0, "R6");
      issue(OP_TSTB, AM_DIR, 8'h80, 0, 0, "R6");

      // R7: load immediate
      issue(OP_LDI, AM_DIR, 8'hF3, 0, 8'h3C, "R7");
      issue(OP_RD, AM_DIR, 8'hF3, 0, 0, "R7");
      issue(OP_LDI, AM_DIR, 8'h20, 0, 8'h77, "R7");
      issue(OP_RD, AM_DIR, 8'h20, 0, 0, "R7");

      // R8: decrement-and-skip
      issue(OP_LDI, AM_DIR, 8'hF5, 0, 8'h02, "R8");
      issue(OP_DRSZ, AM_DIR, 8'hF5, 0, 0, "R8");
      issue(OP_DRSZ, AM_DIR, 8'hF5, 0, 0, "R8");
      issue(OP_DRSZ, AM_DIR, 8'hF5, 0, 0, "R8");
      issue(OP_RD, AM_DIR, 8'hF5, 0, 0, "R8");
      issue(OP_DRSZ, AM_DIR, 8'h10, 0, 0, "R8");
      issue(OP_RD, AM_DIR, 8'h10, 0, 0, "R8");
      issue(OP_LDI, AM_DIR, 8'hF6, 0, 8'h01, "R8");
      issue(OP_LDI, AM_DIR, 8'hF7, 0, 8'h01, "R8");
      issue(OP_DRSZ, AM_DIR, 8'hF6, 0, 0, "R8");
      issue(OP_DRSZ, AM_DIR, 8'hF7, 0, 0, "R8");
      issue(OP_NOP, AM_DIR, 8'h00, 0, 0, "R8");

      // R9: pointer-indirect addressing
      issue(OP_LDI, AM_DIR, 8'hFC, 0, 8'h10, "R9");
      issue(OP_WR, AM_X, 8'h00, 0, 8'h99, "R9");
      issue(OP_RD, AM_DIR, 8'h10, 0, 0, "R9");
      issue(OP_LDI, AM_DIR, 8'hFD, 0, 8'hF2, "R9");
      issue(OP_SETB, AM_B, 8'h00, 0, 0, "R9");
      issue(OP_CLRB, AM_B, 8'h00, 2, 0, "R9");
      issue(OP_RD, AM_DIR, 8'hF2, 0, 0, "R9");
      issue(OP_LDI, AM_DIR, 8'hFE, 0, 8'h6E, "R9");
      issue(OP_RD, AM_SP, 8'h00, 0, 0, "R9");
      issue(OP_TSTB, AM_SP, 8'h00, 1, 0, "R9");
      issue(OP_LDI, AM_DIR, 8'hFC, 0, 8'h80, "R9");
      issue(OP_WR, AM_X, 8'h00, 0, 8'h55, "R9");
      issue(OP_RD, AM_X, 8'h00, 0, 0, "R9");

      repeat (3) issue(OP_NOP, AM_DIR, 8'h00, 0, 0, "R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule